// File: doc/BRIEF.md
# RAM-Based Multi-Tap Delay Line

This block is a delay line with several evenly spaced taps. Its storage is a set of RAMs used as circular buffers, not a chain of flip-flops. On each clock where the shift enable is high and clear is low, one word of `W` bits enters. Tap `k` shows the word that entered `k*M` enabled clocks earlier. All taps are packed into one `W*N`-bit output word. Typical uses are FIR filter sample histories, multi-channel delay and correlation windows.

The line has `N` stages. Each stage reads the old word at its current address and writes the incoming word there in the same cycle. This read-before-write pattern maps onto a read-first block RAM. The first stage's registered read output feeds the next stage. Counters that wrap at the buffer depth produce the addresses. A tap stays at zero until enough words have entered to fill it. A synchronous clear restarts the fill, and the taps stay masked until the buffer has refilled.

Top module: `tapline_shift`

## Requirements
- R1: `taps_out` is `W*N` bits wide. Tap `k` (k = 1..N) occupies bits `[k*W-1 : (k-1)*W]`, so tap 1 is the least significant word. Elaboration rejects parameter sets with `W*N > 36`, `W*M*N > 4608` or `M < 2`.
- R2: A word pushed on enabled clock `t` appears on tap `k` right after enabled clock `t + k*M`. It stays there until the next enabled clock.
- R3: After reset or clear, tap `k` reads zero until more than `k*M` words have been pushed. The taps become valid in order, tap 1 first.
- R4: While `shift_en` is low and `clr` is low, `taps_out` holds its value. `shift_in` is ignored and nothing advances. Later outputs show that no word was taken in during the hold.
- R5: A high `clr` zeroes every tap at the next clock edge and restarts the fill count. `clr` takes priority over `shift_en`: the word presented together with `clr` is not stored.
- R6: While `rst` is high, every tap reads zero after the clock edge. After reset, the line behaves as if it were empty.
- R7: Delays count enabled clocks only. An irregular enable pattern gives the same tap contents as the same words pushed back to back.
- R8: The buffer addresses wrap modulo the stage depth. Output stays correct over runs many times longer than `N*M`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the fill state, active high, overrides `shift_en` |
| shift_en | input | 1 | Push `shift_in` and advance the line |
| shift_in | input | W | Word entering the line |
| taps_out | output | W*N | Packed tap outputs, tap 1 in the low word |

## Verification
The line is driven with a counting sequence from empty. Each word is distinct, so a tap read from the wrong slice, a shifted fill threshold or an off-by-one in stage depth shows up at once. A long pseudo-random stream runs through many wraps of the address counters to check the steady state of the circular buffers. Enable gaps, both regular and irregular, separate delays counted in enabled clocks from delays counted in raw clocks. Holds with a changing input show whether anything leaks in while disabled. A clear with enable high, followed by a refill, shows whether the word presented with the clear was dropped and whether the masking restarts. A reset in the middle of a stream is covered as well.

// File: rtl/tapline_pkg.sv
package tapline_pkg;

  // Capacity limits of one storage macro
  localparam int unsigned STORE_BITS_MAX = 4608;
  localparam int unsigned TAP_BITS_MAX   = 36;

  // Address width for a buffer of the given depth (at least one bit)
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tapline_modcnt.sv
// Wrapping address counter for one circular buffer.
module tapline_modcnt #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  generate
    if (DEPTH <= 1) begin : g_single
      assign addr = '0;
    end else begin : g_wrap
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          addr_q <= '0;
        end else if (adv) begin
          addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
        end
      end
      assign addr = addr_q;
    end
  endgenerate

endmodule

// File: rtl/tapline_ram_stage.sv
// One delay stage: read-first RAM, registered read port.
module tapline_ram_stage #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);

  logic [W-1:0] mem [DEPTH];

  // Write port, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= din;
    end
  end

  // Read port sees the old contents at the written address
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (we) begin
      dout <= mem[addr];
    end
  end

endmodule

// File: rtl/tapline_fill.sv
// Tracks how many words have entered since reset or clear and flags valid taps.
module tapline_fill #(
  parameter int unsigned M = 4,
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  output logic [N-1:0] tap_valid
);

  localparam int unsigned FULL = N * M;
  localparam int unsigned CW   = $clog2(FULL + 1);
  localparam logic [CW-1:0] FULL_C = CW'(FULL);

  logic [CW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill_q <= '0;
    end else if (push && (fill_q != FULL_C)) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  generate
    for (genvar k = 0; k < N; k++) begin : g_valid
      localparam logic [CW-1:0] NEED = CW'((k + 1) * M);
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          tap_valid[k] <= 1'b0;
        end else if (push) begin
          tap_valid[k] <= (fill_q >= NEED);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/tapline_shift.sv
module tapline_shift
  import tapline_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4,
  parameter int unsigned N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           shift_en,
  input  logic [W-1:0]   shift_in,
  output logic [W*N-1:0] taps_out
);

  // First stage spans M words; later stages take one word from the
  // previous stage's read register, so their RAMs hold M-1 words.
  localparam int unsigned HEAD_D  = M;
  localparam int unsigned TAIL_D  = (M > 1) ? M - 1 : 1;
  localparam int unsigned HEAD_AW = addr_bits(HEAD_D);
  localparam int unsigned TAIL_AW = addr_bits(TAIL_D);

  generate
    if ((W * N > TAP_BITS_MAX) || (W * M * N > STORE_BITS_MAX) || (M < 2)) begin : g_bad_cfg
      $error("tapline_shift: parameters exceed storage or tap width limits");
    end
  endgenerate

  logic               push;
  logic [HEAD_AW-1:0] head_addr;
  logic [TAIL_AW-1:0] tail_addr;
  logic [N-1:0]       tap_valid;
  logic [W-1:0]       stage_q [N];

  assign push = shift_en & ~clr;

  tapline_modcnt #(.DEPTH(HEAD_D), .AW(HEAD_AW)) u_head_cnt (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .adv (push),
    .addr(head_addr)
  );

  generate
    if (N > 1) begin : g_tail_cnt
      tapline_modcnt #(.DEPTH(TAIL_D), .AW(TAIL_AW)) u_tail_cnt (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .adv (push),
        .addr(tail_addr)
      );
    end else begin : g_no_tail
      assign tail_addr = '0;
    end
  endgenerate

  tapline_fill #(.M(M), .N(N)) u_fill (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .push     (push),
    .tap_valid(tap_valid)
  );

  generate
    for (genvar k = 0; k < N; k++) begin : g_stage
      if (k == 0) begin : g_head
        tapline_ram_stage #(.W(W), .DEPTH(HEAD_D), .AW(HEAD_AW)) u_ram (
          .clk (clk),
          .rst (rst),
          .we  (push),
          .addr(head_addr),
          .din (shift_in),
          .dout(stage_q[k])
        );
      end else begin : g_tail
        tapline_ram_stage #(.W(W), .DEPTH(TAIL_D), .AW(TAIL_AW)) u_ram (
          .clk (clk),
          .rst (rst),
          .we  (push),
          .addr(tail_addr),
          .din (stage_q[k-1]),
          .dout(stage_q[k])
        );
      end
      assign taps_out[k*W +: W] = stage_q[k] & {W{tap_valid[k]}};
    end
  endgenerate

endmodule

// File: rtl/tapline_shift_chk.sv
module tapline_shift_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned M       = 4,
  parameter int unsigned N       = 3,
  parameter int unsigned HEAD_AW = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               shift_en,
  input logic [W*N-1:0]     taps_out,
  input logic [N-1:0]       tap_valid,
  input logic [HEAD_AW-1:0] head_addr
);

  localparam int unsigned AWX = HEAD_AW + 1;

  assert_reset_zero_R6: assert property (@(posedge clk)
    rst |=> (taps_out == '0));

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (taps_out == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clr) |=> $stable(taps_out));

  assert_fill_order_R3: assert property (@(posedge clk) disable iff (rst)
    ((N'(tap_valid + 1'b1) & tap_valid) == '0));

  assert_first_tap_push_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_valid[0]) |-> $past(shift_en && !clr));

  assert_addr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (AWX'(head_addr) < AWX'(M)));

endmodule

bind tapline_shift tapline_shift_chk #(
  .W(W), .M(M), .N(N), .HEAD_AW(HEAD_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .shift_en (shift_en),
  .taps_out (taps_out),
  .tap_valid(tap_valid),
  .head_addr(head_addr)
);

// File: tb/tb_tapline_shift.sv
module tb_tapline_shift;

  localparam int W = 8;
  localparam int M = 4;
  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst;
  logic           clr;
  logic           shift_en;
  logic [W-1:0]   shift_in;
  logic [W*N-1:0] taps_out;

  int         checks = 0;
  int         fails  = 0;
  int         pushes = 0;
  logic [W-1:0] hist [$];
  logic [W-1:0] seed = 8'h3B;

  always #5 clk = ~clk;

  tapline_shift #(.W(W), .M(M), .N(N)) dut (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .shift_en(shift_en),
    .shift_in(shift_in),
    .taps_out(taps_out)
  );

  // Expected packed taps: tap k (1-based) holds the word pushed k*M pushes ago (R1, R2, R3)
  function automatic logic [W*N-1:0] model();
    logic [W*N-1:0] e;
    e = '0;
    for (int k = 1; k <= N; k++) begin
      if (pushes > k * M) e[(k-1)*W +: W] = hist[pushes - 1 - k*M];
    end
    return e;
  endfunction

  task automatic check(input string req);
    logic [W*N-1:0] e;
    e = model();
    checks++;
    if (taps_out !== e) begin
      fails++;
      $display("FAIL %s: taps_out=%h expected %h", req, taps_out, e);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge
  task automatic step(input bit en, input bit c, input logic [W-1:0] d, input string req);
    shift_en = en;
    clr      = c;
    shift_in = d;
    @(posedge clk);
    if (rst || c) begin
      hist.delete();
      pushes = 0;
    end else if (en) begin
      hist.push_back(d);
      pushes++;
    end
    @(negedge clk);
    check(req);
  endtask

  function automatic logic [W-1:0] next_word();
    seed = seed * 8'd29 + 8'd17;
    return seed;
  endfunction

  task automatic t_reset();
    rst = 1'b1; clr = 1'b0; shift_en = 1'b0; shift_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6");
    step(1'b1, 1'b0, 8'hEE, "R6");
    rst = 1'b0;
  endtask

  // Distinct counting words make slice placement and fill thresholds visible
  task automatic t_fill();
    for (int i = 0; i < N*M + 4; i++) step(1'b1, 1'b0, W'(i + 1), (i < N*M) ? "R3" : "R1");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 12*N*M; i++) step(1'b1, 1'b0, next_word(), (i % 2 == 0) ? "R2" : "R8");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, next_word(), "R4");
    for (int i = 0; i < N*M + 2; i++) step(1'b1, 1'b0, next_word(), "R4");
  endtask

  task automatic t_gappy();
    for (int i = 0; i < 60; i++) step((i % 3 != 1) && (i % 7 != 5), 1'b0, next_word(), "R7");
  endtask

  task automatic t_clear();
    step(1'b1, 1'b1, 8'h5C, "R5");
    for (int i = 0; i < N*M + 3; i++) step(1'b1, 1'b0, W'(8'h80 + i), "R5");
    step(1'b0, 1'b1, 8'h11, "R5");
    for (int i = 0; i < M + 2; i++) step(1'b1, 1'b0, next_word(), "R5");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, next_word(), "R2");
    rst = 1'b1;
    step(1'b1, 1'b0, 8'hA5, "R6");
    rst = 1'b0;
    for (int i = 0; i < N*M + 3; i++) step(1'b1, 1'b0, next_word(), "R6");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_stream();
    t_hold();
    t_gappy();
    t_clear();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run still busy (actual hung, expected finished)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule